// File: doc/BRIEF.md
# Serial Byte Transmitter with Holding Register

This block sends bytes on an asynchronous serial line. A byte written into its single holding register moves into a shift register and leaves the block as a frame: a low start bit, seven or eight data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. The start, parity and stop bits are added by the block. An external baud generator supplies a tick strobe, and every bit on the line lasts sixteen of those ticks.

Two control inputs gate the block. The port enable drives the idle-high line as soon as it is set and abandons all activity when it is cleared. The transmit enable decides whether a write to the holding register is accepted. A one-cycle completion pulse marks the moment the final stop bit starts, so software can load the next byte early. Because the holding register is separate from the shift register, a byte written during a frame follows the current frame with no idle gap. A byte is accepted only while both enables are set.

Top module: `sertx_top`

## Requirements
- R1: After reset `serOut` equals `portEn`, and `txBusy` and `txDone` are 0.
- R2: `serOut` goes high in the same cycle that `portEn` rises, before any transmit enable, and stays low for as long as `portEn` is 0.
- R3: A `bufWr` strobe while `txEn` is 0 is discarded: no frame starts, `txBusy` stays 0, and setting `txEn` later does not send the discarded byte.
- R4: A frame is, in line order, one start bit of value 0, then the data bits least significant first, then the parity bit when enabled, then the stop bits of value 1. The start bit appears on `serOut` two clock edges after the edge that samples `bufWr`.
- R5: `cfgLen8` = 1 sends 8 data bits. `cfgLen8` = 0 sends bits 6..0 only, and bit 7 is left out of the frame and of the parity.
- R6: `cfgParity` selects the parity bit: 0 = no parity bit, 1 = even (bit equals the XOR of the data bits sent), 2 = odd (its inverse), 3 = a bit that is always 0. `cfgStop2` = 1 selects two stop bits, 0 selects one.
- R7: Every bit stays on the line for exactly 16 cycles in which `baudTick` is high. While `baudTick` is low, the line holds its value.
- R8: `txDone` is a single-cycle pulse in the first cycle of the last stop bit. With two stop bits it comes 16 ticks later than with one.
- R9: `txBusy` rises in the cycle after an accepted write and falls in the cycle after the last stop bit ends, unless another byte is waiting.
- R10: A byte accepted while a frame is on the line is held. Its start bit follows the last stop bit of the current frame directly.
- R11: Clearing `portEn` drops the frame in progress and the held byte. It produces no `txDone`. When `portEn` returns, the line is idle high.
- R12: A reset during a frame empties the block without any `txDone` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Port enable; line idles high while set |
| txEn | input | 1 | Transmit enable; gates buffer writes |
| baudTick | input | 1 | Baud strobe, 16 per bit |
| bufWr | input | 1 | Holding register write strobe |
| bufData | input | 8 | Byte to send |
| cfgLen8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfgParity | input | 2 | 0 none, 1 even, 2 odd, 3 forced zero |
| cfgStop2 | input | 1 | 1 = two stop bits |
| serOut | output | 1 | Serial line |
| txDone | output | 1 | Pulse at start of last stop bit |
| txBusy | output | 1 | Frame in progress or byte held |

## Verification
The hardest case to reach from the ports is the hand-over from a finished frame to a byte that was queued during it. A second write has to land while the first frame is in its data bits, after the holding register has been emptied but before the stop bits. The stimulus makes this write partway through a checked frame. It then expects the next start bit on the very cycle the previous stop bit ends. The abort cases are reached the same way: enable removal and reset are applied in the middle of the data bits, and the bench then watches several hundred cycles for a completion pulse that must never appear.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } txState_t;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_ZERO = 2'd3
  } parMode_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // copy holding register into shifter, drive start bit
    logic shift;   // drive next data bit
    logic parity;  // drive parity bit
    logic mark;    // drive a high (stop or idle) level
    logic flush;   // port disabled: drop everything
  } txStrobe_t;

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      portEn,
  input  logic      baudTick,
  input  logic      bufFull,
  input  logic      cfgLen8,
  input  logic [1:0] cfgParity,
  input  logic      cfgStop2,
  output txStrobe_t strb,
  output logic      txDone,
  output logic      frameActive
);

  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

  txState_t         state, nextState;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             lenFull, parOn, stopTwo;
  logic             bitEnd, frameEnd, lastStopEnter;
  logic [IDX_W-1:0] lastDataIdx;

  assign bitEnd      = baudTick && (tickCnt == LAST_TICK);
  assign lastDataIdx = lenFull ? LAST_LONG : LAST_SHORT;
  assign frameActive = (state != ST_IDLE);

  always_comb begin
    nextState     = state;
    strb          = '0;
    frameEnd      = 1'b0;
    lastStopEnter = 1'b0;
    if (!portEn) begin
      nextState  = ST_IDLE;
      strb.flush = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (bufFull) begin
            nextState = ST_START;
            strb.load = 1'b1;
          end
        end
        ST_START: begin
          if (bitEnd) begin
            nextState  = ST_DATA;
            strb.shift = 1'b1;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            if (bitIdx != lastDataIdx) begin
              strb.shift = 1'b1;
            end else if (parOn) begin
              nextState   = ST_PARITY;
              strb.parity = 1'b1;
            end else begin
              nextState     = ST_STOP1;
              strb.mark     = 1'b1;
              lastStopEnter = !stopTwo;
            end
          end
        end
        ST_PARITY: begin
          if (bitEnd) begin
            nextState     = ST_STOP1;
            strb.mark     = 1'b1;
            lastStopEnter = !stopTwo;
          end
        end
        ST_STOP1: begin
          if (bitEnd) begin
            if (stopTwo) begin
              nextState     = ST_STOP2;
              strb.mark     = 1'b1;
              lastStopEnter = 1'b1;
            end else begin
              frameEnd = 1'b1;
            end
          end
        end
        ST_STOP2: begin
          if (bitEnd) frameEnd = 1'b1;
        end
        default: nextState = ST_IDLE;
      endcase
      if (frameEnd) begin
        if (bufFull) begin
          nextState = ST_START;
          strb.load = 1'b1;
        end else begin
          nextState = ST_IDLE;
          strb.mark = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      lenFull <= 1'b1;
      parOn   <= 1'b0;
      stopTwo <= 1'b0;
      txDone  <= 1'b0;
    end else begin
      state  <= nextState;
      txDone <= lastStopEnter;
      if (strb.load || strb.flush) begin
        tickCnt <= '0;
      end else if (frameActive && baudTick) begin
        tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
      end
      if (strb.load) begin
        bitIdx  <= '0;
        lenFull <= cfgLen8;
        parOn   <= (parMode_t'(cfgParity) != PAR_NONE);
        stopTwo <= cfgStop2;
      end else if (state == ST_DATA && bitEnd) begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  // R11
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> (state == ST_IDLE && !txDone));

  // R7
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portEn && frameActive && !baudTick && !frameEnd) |=> (state == $past(state)));

endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              txEn,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] bufData,
  input  logic              cfgLen8,
  input  logic [1:0]        cfgParity,
  input  txStrobe_t         strb,
  output logic              bufFull,
  output logic              serOut
);

  localparam logic [DATA_W-1:0] MASK_LONG  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] MASK_SHORT = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] bufReg, shiftReg, dataMask;
  logic              parBit, parNext, onesOdd, lineReg, wrAccept;

  assign wrAccept = bufWr && portEn && txEn;
  assign dataMask = cfgLen8 ? MASK_LONG : MASK_SHORT;
  assign onesOdd  = ^(bufReg & dataMask);

  always_comb begin
    unique case (parMode_t'(cfgParity))
      PAR_EVEN: parNext = onesOdd;
      PAR_ODD:  parNext = !onesOdd;
      default:  parNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg   <= '0;
      bufFull  <= 1'b0;
      shiftReg <= '0;
      parBit   <= 1'b0;
      lineReg  <= 1'b1;
    end else if (strb.flush) begin
      bufFull <= 1'b0;
      lineReg <= 1'b1;
    end else begin
      if (strb.load) begin
        shiftReg <= bufReg;
        parBit   <= parNext;
        lineReg  <= 1'b0;
        bufFull  <= 1'b0;
      end else if (strb.shift) begin
        lineReg  <= shiftReg[0];
        shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
      end else if (strb.parity) begin
        lineReg <= parBit;
      end else if (strb.mark) begin
        lineReg <= 1'b1;
      end
      if (wrAccept) begin
        bufReg  <= bufData;
        bufFull <= 1'b1;
      end
    end
  end

  assign serOut = portEn && lineReg;

  // R10
  load_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> bufFull);

  // R3
  gated_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufWr && !txEn && !bufFull) |=> !bufFull);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              txEn,
  input  logic              baudTick,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] bufData,
  input  logic              cfgLen8,
  input  logic [1:0]        cfgParity,
  input  logic              cfgStop2,
  output logic              serOut,
  output logic              txDone,
  output logic              txBusy
);

  txStrobe_t strb;
  logic      bufFull;
  logic      frameActive;

  sertx_ctrl #(
    .DATA_W       (DATA_W),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .portEn     (portEn),
    .baudTick   (baudTick),
    .bufFull    (bufFull),
    .cfgLen8    (cfgLen8),
    .cfgParity  (cfgParity),
    .cfgStop2   (cfgStop2),
    .strb       (strb),
    .txDone     (txDone),
    .frameActive(frameActive)
  );

  sertx_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .portEn   (portEn),
    .txEn     (txEn),
    .bufWr    (bufWr),
    .bufData  (bufData),
    .cfgLen8  (cfgLen8),
    .cfgParity(cfgParity),
    .strb     (strb),
    .bufFull  (bufFull),
    .serOut   (serOut)
  );

  assign txBusy = bufFull || frameActive;

  // R8
  done_on_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && portEn) |-> (serOut && txBusy));

  // R9
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portEn && $past(portEn) && $fell(serOut)) |-> txBusy);

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portEn = 1'b0;
  logic       txEn = 1'b0;
  logic       baudTick = 1'b1;
  logic       bufWr = 1'b0;
  logic [7:0] bufData = '0;
  logic       cfgLen8 = 1'b1;
  logic [1:0] cfgParity = 2'd0;
  logic       cfgStop2 = 1'b0;
  logic       serOut, txDone, txBusy;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #10 clk = !clk;

  sertx_top u_dut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .txEn(txEn), .baudTick(baudTick),
    .bufWr(bufWr), .bufData(bufData), .cfgLen8(cfgLen8), .cfgParity(cfgParity),
    .cfgStop2(cfgStop2), .serOut(serOut), .txDone(txDone), .txBusy(txBusy)
  );

  // {data, len8, parity, stop2, expected frame length in bits}
  localparam logic [15:0] VECS [0:7] = '{
    {8'h55, 1'b1, 2'd0, 1'b0, 4'd10},
    {8'hA3, 1'b1, 2'd1, 1'b0, 4'd11},
    {8'h3C, 1'b1, 2'd2, 1'b1, 4'd12},
    {8'h7F, 1'b0, 2'd0, 1'b0, 4'd9},
    {8'h81, 1'b0, 2'd1, 1'b1, 4'd11},
    {8'hFF, 1'b1, 2'd3, 1'b1, 4'd12},
    {8'h00, 1'b1, 2'd2, 1'b0, 4'd11},
    {8'hC6, 1'b0, 2'd2, 1'b0, 4'd10}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [11:0] frameOf(input logic [7:0] d, input logic l8,
                                          input logic [1:0] p);
    logic [11:0] f;
    int          len;
    int          k;
    logic        par;
    f    = '1;
    len  = l8 ? 8 : 7;
    f[0] = 1'b0;
    for (int i = 0; i < len; i++) f[1+i] = d[i];
    k   = 1 + len;
    par = ^(d & (l8 ? 8'hFF : 8'h7F));
    if (p == 2'd1) f[k] = par;
    else if (p == 2'd2) f[k] = !par;
    else if (p == 2'd3) f[k] = 1'b0;
    return f;
  endfunction

  // called at a negedge; returns at the negedge where the start bit is visible
  task automatic writeByte(input logic [7:0] d);
    bufWr   = 1'b1;
    bufData = d;
    @(negedge clk);
    bufWr = 1'b0;
    check(txBusy === 1'b1, "R9", "busy after accepted write", txBusy, 1);
    @(negedge clk);
  endtask

  task automatic checkFrame(input logic [7:0] d, input logic l8, input logic [1:0] p,
                            input int nb, input bit inject, input logic [7:0] injData,
                            input bit expectNext);
    logic [11:0] f;
    int bitErr, doneErr, busyErr;
    f = frameOf(d, l8, p);
    bitErr = 0; doneErr = 0; busyErr = 0;
    for (int c = 0; c < nb * 16; c++) begin
      if ((c % 16) == 8 && serOut !== f[c/16]) begin
        bitErr++;
        $display("FAIL R4 R5 R6 data=%02h bit %0d actual=%0b expected=%0b",
                 d, c/16, serOut, f[c/16]);
      end
      if (txDone !== (c == (nb - 1) * 16)) doneErr++;
      if (txBusy !== 1'b1) busyErr++;
      if (inject && c == 20) begin bufWr = 1'b1; bufData = injData; end
      if (inject && c == 21) bufWr = 1'b0;
      @(negedge clk);
    end
    checks++;
    if (bitErr != 0) errors++;
    check(doneErr == 0, "R8", "done pulse position mismatches", doneErr, 0);
    check(busyErr == 0, "R9", "busy low during frame", busyErr, 0);
    if (expectNext) begin
      check(serOut === 1'b0, "R10", "next start bit follows stop", serOut, 0);
      check(txBusy === 1'b1, "R10", "busy across frames", txBusy, 1);
    end else begin
      check(serOut === 1'b1, "R9", "idle line after frame", serOut, 1);
      check(txBusy === 1'b0, "R9", "busy cleared after frame", txBusy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(serOut === 1'b0, "R1", "line with port disabled", serOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(serOut === 1'b0 && txBusy === 1'b0 && txDone === 1'b0, "R1", "outputs after reset",
          {serOut, txBusy, txDone}, 0);
    // R2 line high right away
    portEn = 1'b1;
    #1;
    check(serOut === 1'b1, "R2", "line high on enable", serOut, 1);
    @(negedge clk);

    // R3 write while transmit disabled
    bufWr = 1'b1; bufData = 8'h5A;
    @(negedge clk);
    bufWr = 1'b0;
    begin
      int low = 0;
      for (int i = 0; i < 40; i++) begin
        if (serOut !== 1'b1 || txBusy !== 1'b0) low++;
        @(negedge clk);
      end
      txEn = 1'b1;
      for (int i = 0; i < 40; i++) begin
        if (serOut !== 1'b1 || txBusy !== 1'b0) low++;
        @(negedge clk);
      end
      check(low == 0, "R3", "activity after gated write", low, 0);
    end

    // table of frames
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = VECS[i];
      cfgLen8   = v[7];
      cfgParity = v[6:5];
      cfgStop2  = v[4];
      writeByte(v[15:8]);
      checkFrame(v[15:8], v[7], v[6:5], int'(v[3:0]), 1'b0, 8'h00, 1'b0);
      repeat (5) @(negedge clk);
    end

    // R10 back-to-back frames
    cfgLen8 = 1'b1; cfgParity = 2'd1; cfgStop2 = 1'b1;
    writeByte(8'h96);
    checkFrame(8'h96, 1'b1, 2'd1, 12, 1'b1, 8'h4B, 1'b1);
    checkFrame(8'h4B, 1'b1, 2'd1, 12, 1'b0, 8'h00, 1'b0);

    // R7 line holds without ticks, then 16 ticks per bit
    cfgParity = 2'd0; cfgStop2 = 1'b0;
    writeByte(8'hFF);
    baudTick = 1'b0;
    begin
      int moved = 0;
      int cnt = 0;
      for (int i = 0; i < 40; i++) begin
        if (serOut !== 1'b0) moved++;
        @(negedge clk);
      end
      check(moved == 0, "R7", "line moved without ticks", moved, 0);
      baudTick = 1'b1;
      do begin
        @(negedge clk);
        cnt++;
      end while (serOut === 1'b0 && cnt < 100);
      check(cnt == 16, "R7", "cycles of start bit after resume", cnt, 16);
      repeat (9 * 16) @(negedge clk);
      check(txBusy === 1'b0 && serOut === 1'b1, "R7", "idle after stalled frame",
            {txBusy, serOut}, 1);
    end

    // R11 port disable mid-frame
    cfgParity = 2'd2; cfgStop2 = 1'b1;
    writeByte(8'h3A);
    bufWr = 1'b1; bufData = 8'hE1;
    @(negedge clk);
    bufWr = 1'b0;
    repeat (30) @(negedge clk);
    portEn = 1'b0;
    #1;
    check(serOut === 1'b0, "R11", "line low while disabled", serOut, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 250; i++) begin
        @(negedge clk);
        if (txDone !== 1'b0 || serOut !== 1'b0 || txBusy !== 1'b0) bad++;
      end
      check(bad == 0, "R11", "activity while disabled", bad, 0);
      portEn = 1'b1;
      #1;
      check(serOut === 1'b1, "R11", "idle high on re-enable", serOut, 1);
      bad = 0;
      for (int i = 0; i < 250; i++) begin
        @(negedge clk);
        if (txDone !== 1'b0 || serOut !== 1'b1 || txBusy !== 1'b0) bad++;
      end
      check(bad == 0, "R11", "frame or held byte resumed", bad, 0);
    end

    // R12 reset mid-frame
    cfgStop2 = 1'b0;
    writeByte(8'hC3);
    repeat (30) @(negedge clk);
    rstN = 1'b0;
    #1;
    check(txDone === 1'b0 && txBusy === 1'b0, "R12", "outputs in reset", {txDone, txBusy}, 0);
    @(negedge clk);
    rstN = 1'b1;
    begin
      int bad = 0;
      for (int i = 0; i < 250; i++) begin
        @(negedge clk);
        if (txDone !== 1'b0 || serOut !== 1'b1 || txBusy !== 1'b0) bad++;
      end
      check(bad == 0, "R12", "done or activity after reset", bad, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule